// File: doc/BRIEF.md
# Delayed-Redirect Next-PC Unit

This block decides where a 32-bit RISC front end fetches next. Each time the fetch stage advances, it evaluates the control-transfer kind decoded for the instruction at the current PC. The inputs to that decision are two register operands, a 16-bit branch displacement, a 26-bit jump field and a register-held jump address. There are no condition codes. A conditional branch either compares two full registers or tests one register's two's-complement sign and zero state.

A taken transfer does not redirect fetch at once. The next fetch is always the sequential instruction, which is the delay slot. The resolved target is held in a register and becomes the fetch address one advance later. Jump-and-link also raises a write request for link register 31, carrying the current PC plus 4. A transfer decoded in a delay slot is suppressed.

Top module: `npc_unit`

## Requirements
- R1: After reset no redirect is pending: `next_pc` equals `cur_pc`+4, and the first taken transfer still gets its own delay slot.
- R2: Kind 1 (equal) is taken when all 32 bits of `opnd_a` and `opnd_b` match. Kind 2 (not equal) is taken when any bit differs.
- R3: Kinds 3, 4, 5 and 6 test `opnd_a` as a signed value against zero: 3 is taken for <=0, 4 for >0, 5 for <0 and 6 for >=0.
- R4: A taken conditional branch targets `cur_pc`+4 plus `br_off`, sign-extended and multiplied by 4.
- R5: Kind 7 (jump) is always taken. Its target is bits 31:28 of `cur_pc`+4, followed by `jmp_field`, followed by two zero bits.
- R6: Kind 8 (register jump) is always taken and targets `jr_addr` unchanged.
- R7: Kind 9 (jump and link) is taken with the same target as kind 7. It raises `link_we` with `link_idx`=31 and `link_data`=`cur_pc`+4.
- R8: On the advance where `taken` is 1, `next_pc` is `cur_pc`+4. On the following advance, `next_pc` is the resolved target.
- R9: On a delay-slot advance, `taken` and `link_we` stay 0 whatever kind is decoded, and `next_pc` is the held target.
- R10: With `adv` low, `taken` and `link_we` are 0 and a pending redirect and its target are kept unchanged.
- R11: Kind 0 and kinds 10 to 15 are not transfers: never taken, no link write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adv | input | 1 | Fetch stage advances this cycle |
| cur_pc | input | 32 | PC of the instruction being resolved |
| xfer_kind | input | 4 | Decoded control-transfer kind |
| opnd_a | input | 32 | First register operand |
| opnd_b | input | 32 | Second register operand |
| br_off | input | 16 | Branch displacement in words |
| jmp_field | input | 26 | Direct jump target field |
| jr_addr | input | 32 | Register jump address |
| next_pc | output | 32 | Address to fetch next |
| taken | output | 1 | Transfer taken on this advance |
| link_we | output | 1 | Link register write request |
| link_idx | output | 5 | Link register index |
| link_data | output | 32 | Return address to write |

## Verification
The bench targets equality operands that differ only in the sign bit, and the zero tests at 0, -1 and the most negative value. A design that compared fewer bits, or tested the sign unsigned, would then take the wrong branch. A jump placed so that PC+4 carries into the top nibble exposes a target built from the unincremented PC. A maximal backward displacement exposes a missing sign extension. Stalls between a taken branch and its slot, and a jump-and-link placed in a slot, show whether the held target is lost or a second redirect and link write slip through.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int XW      = 32;
  localparam int OFF_W   = 16;
  localparam int JF_W    = 26;
  localparam int KIND_W  = 4;
  localparam int RIDX_W  = 5;
  localparam int INSN_B  = 4;
  localparam int SEG_W   = XW - JF_W - 2;

  typedef enum logic [KIND_W-1:0] {
    XK_NONE = 4'd0,
    XK_BEQ  = 4'd1,
    XK_BNE  = 4'd2,
    XK_BLEZ = 4'd3,
    XK_BGTZ = 4'd4,
    XK_BLTZ = 4'd5,
    XK_BGEZ = 4'd6,
    XK_J    = 4'd7,
    XK_JR   = 4'd8,
    XK_JAL  = 4'd9
  } xfer_e;

  function automatic logic [XW-1:0] f_seq(input logic [XW-1:0] pc);
    return pc + XW'(INSN_B);
  endfunction

  function automatic logic [XW-1:0] f_br_tgt(input logic [XW-1:0] pc,
                                             input logic [OFF_W-1:0] off);
    logic [XW-1:0] disp;
    disp = {{(XW-OFF_W-2){off[OFF_W-1]}}, off, 2'b00};
    return f_seq(pc) + disp;
  endfunction

  function automatic logic [XW-1:0] f_jmp_tgt(input logic [XW-1:0] pc,
                                              input logic [JF_W-1:0] fld);
    logic [XW-1:0] s;
    s = f_seq(pc);
    return {s[XW-1 -: SEG_W], fld, 2'b00};
  endfunction
endpackage

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
(
  input  logic [KIND_W-1:0] kind,
  input  logic [XW-1:0]     a,
  input  logic [XW-1:0]     b,
  output logic              cond_true,
  output logic              is_link
);
  logic ops_eq, a_neg, a_zero;
  xfer_e k;

  assign k      = xfer_e'(kind);
  assign ops_eq = (a == b);
  assign a_neg  = a[XW-1];
  assign a_zero = (a == '0);

  always_comb begin
    cond_true = 1'b0;
    case (k)
      XK_BEQ:  cond_true = ops_eq;
      XK_BNE:  cond_true = !ops_eq;
      XK_BLEZ: cond_true = a_neg || a_zero;
      XK_BGTZ: cond_true = !a_neg && !a_zero;
      XK_BLTZ: cond_true = a_neg;
      XK_BGEZ: cond_true = !a_neg;
      XK_J, XK_JR, XK_JAL: cond_true = 1'b1;
      default: cond_true = 1'b0;
    endcase
  end

  assign is_link = (k == XK_JAL);
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
(
  input  logic [KIND_W-1:0] kind,
  input  logic [XW-1:0]     pc,
  input  logic [OFF_W-1:0]  off,
  input  logic [JF_W-1:0]   fld,
  input  logic [XW-1:0]     jr,
  output logic [XW-1:0]     tgt,
  output logic [XW-1:0]     seq_pc
);
  xfer_e k;
  assign k      = xfer_e'(kind);
  assign seq_pc = f_seq(pc);

  always_comb begin
    case (k)
      XK_J, XK_JAL: tgt = f_jmp_tgt(pc, fld);
      XK_JR:        tgt = jr;
      default:      tgt = f_br_tgt(pc, off);
    endcase
  end
endmodule

// File: rtl/npc_slot.sv
module npc_slot
  import npc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          fire,
  input  logic [XW-1:0] tgt_in,
  output logic          pend_o,
  output logic [XW-1:0] tgt_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_o <= 1'b0;
      tgt_o  <= '0;
    end else if (adv) begin
      pend_o <= fire;
      if (fire) tgt_o <= tgt_in;
    end
  end

  assert_fire_arms_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && fire) |=> (pend_o && tgt_o == $past(tgt_in)));

  assert_slot_drains_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && pend_o) |=> !pend_o);

  assert_stall_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(pend_o) && $stable(tgt_o)));
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int LINK_REG = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [XW-1:0]     cur_pc,
  input  logic [KIND_W-1:0] xfer_kind,
  input  logic [XW-1:0]     opnd_a,
  input  logic [XW-1:0]     opnd_b,
  input  logic [OFF_W-1:0]  br_off,
  input  logic [JF_W-1:0]   jmp_field,
  input  logic [XW-1:0]     jr_addr,
  output logic [XW-1:0]     next_pc,
  output logic              taken,
  output logic              link_we,
  output logic [RIDX_W-1:0] link_idx,
  output logic [XW-1:0]     link_data
);
  logic          cond_true, is_link, pend, fire;
  logic [XW-1:0] tgt, seq_pc, held_tgt;

  npc_cond u_cond (
    .kind(xfer_kind), .a(opnd_a), .b(opnd_b),
    .cond_true(cond_true), .is_link(is_link)
  );

  npc_target u_tgt (
    .kind(xfer_kind), .pc(cur_pc), .off(br_off), .fld(jmp_field),
    .jr(jr_addr), .tgt(tgt), .seq_pc(seq_pc)
  );

  assign fire = adv && !pend && cond_true;

  npc_slot u_slot (
    .clk(clk), .rst_n(rst_n), .adv(adv), .fire(fire),
    .tgt_in(tgt), .pend_o(pend), .tgt_o(held_tgt)
  );

  assign taken     = fire;
  assign link_we   = adv && !pend && is_link;
  assign link_idx  = RIDX_W'(LINK_REG);
  assign link_data = seq_pc;
  assign next_pc   = pend ? held_tgt : seq_pc;

  assert_slot_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (!taken && !link_we));

  assert_link_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (taken && link_data == cur_pc + 32'd4));

  assert_jump_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !pend && xfer_kind == XK_J) |-> taken);

  assert_slot_sequential_R8: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> next_pc == cur_pc + 32'd4);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |-> (!taken && !link_we));
endmodule

// File: tb/sim_npc_unit.sv
module sim_npc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adv = 1'b0;
  logic [31:0] cur_pc = 32'h100;
  logic [3:0]  xfer_kind = 4'd0;
  logic [31:0] opnd_a = 32'd0, opnd_b = 32'd0, jr_addr = 32'd0;
  logic [15:0] br_off = 16'd0;
  logic [25:0] jmp_field = 26'd0;
  logic [31:0] next_pc, link_data;
  logic        taken, link_we;
  logic [4:0]  link_idx;

  int n_chk = 0, n_bad = 0;
  bit m_pend = 0;
  logic [31:0] m_tgt = 32'd0;
  logic [31:0] m_pc = 32'h100;

  always #10 clk = ~clk;

  npc_unit u0 (
    .clk(clk), .rst_n(rst_n), .adv(adv), .cur_pc(cur_pc), .xfer_kind(xfer_kind),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .br_off(br_off), .jmp_field(jmp_field),
    .jr_addr(jr_addr), .next_pc(next_pc), .taken(taken), .link_we(link_we),
    .link_idx(link_idx), .link_data(link_data)
  );

  function automatic bit e_cond(input int k, input logic [31:0] a, input logic [31:0] b);
    int sa;
    sa = $signed(a);
    case (k)
      1: return a == b;
      2: return a != b;
      3: return sa <= 0;
      4: return sa > 0;
      5: return sa < 0;
      6: return sa >= 0;
      7, 8, 9: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] e_tgt(input int k, input logic [31:0] pc,
      input logic [15:0] off, input logic [25:0] fld, input logic [31:0] jr);
    int d;
    d = $signed(off);
    if (k == 7 || k == 9) return ((pc + 32'd4) & 32'hF000_0000) | ({6'd0, fld} * 32'd4);
    if (k == 8) return jr;
    return pc + 32'd4 + 32'(d * 4);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit a, input int k, input logic [31:0] oa, input logic [31:0] ob,
                      input logic [15:0] off, input logic [25:0] fld, input logic [31:0] jr,
                      input string req);
    bit et, el;
    logic [31:0] en, tg;
    adv = a; xfer_kind = 4'(k); opnd_a = oa; opnd_b = ob;
    br_off = off; jmp_field = fld; jr_addr = jr; cur_pc = m_pc;
    tg = e_tgt(k, m_pc, off, fld, jr);
    et = a && !m_pend && e_cond(k, oa, ob);
    el = a && !m_pend && (k == 9);
    en = m_pend ? m_tgt : m_pc + 32'd4;
    @(negedge clk);
    chk({req, " next_pc"}, next_pc, en);
    chk({req, " taken"}, {31'd0, taken}, {31'd0, et});
    chk({req, " link_we"}, {31'd0, link_we}, {31'd0, el});
    if (el) begin
      chk({req, " R7 link_idx"}, {27'd0, link_idx}, 32'd31);
      chk({req, " R7 link_data"}, link_data, m_pc + 32'd4);
    end
    @(posedge clk);
    if (a) begin
      if (et) begin m_pend = 1; m_tgt = tg; end
      else m_pend = 0;
      m_pc = en;
    end
    #1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    // R1: idle after reset
    step(0, 0, 0, 0, 0, 0, 0, "R1 idle");
    // R1: first taken branch after reset still gets a slot
    step(1, 1, 32'h5, 32'h5, 16'h0010, 0, 0, "R1 R2 beq taken");
    step(1, 0, 0, 0, 0, 0, 0, "R8 slot");
    step(1, 0, 0, 0, 0, 0, 0, "R8 redirect");
    // R2: sign-bit-only difference
    step(1, 1, 32'h8000_0000, 32'h0, 16'h4, 0, 0, "R2 beq msb differs");
    step(1, 2, 32'h8000_0000, 32'h0, 16'h4, 0, 0, "R2 bne msb differs");
    step(1, 0, 0, 0, 0, 0, 0, "R8 slot");
    step(1, 2, 32'h1234, 32'h1234, 16'h4, 0, 0, "R2 bne equal");
    // R3: zero tests at corner values
    for (int k = 3; k <= 6; k++) begin
      step(1, k, 32'h0, 0, 16'h2, 0, 0, "R3 zero");
      if (m_pend) step(1, 0, 0, 0, 0, 0, 0, "R3 slot");
      step(1, k, 32'hFFFF_FFFF, 0, 16'h2, 0, 0, "R3 minus one");
      if (m_pend) step(1, 0, 0, 0, 0, 0, 0, "R3 slot");
      step(1, k, 32'h8000_0000, 0, 16'h2, 0, 0, "R3 most negative");
      if (m_pend) step(1, 0, 0, 0, 0, 0, 0, "R3 slot");
      step(1, k, 32'h7FFF_FFFF, 0, 16'h2, 0, 0, "R3 most positive");
      if (m_pend) step(1, 0, 0, 0, 0, 0, 0, "R3 slot");
    end
    // R4: maximal backward displacement
    m_pc = 32'h0004_0000;
    step(1, 1, 0, 0, 16'h8000, 0, 0, "R4 back max");
    step(1, 0, 0, 0, 0, 0, 0, "R4 slot");
    step(1, 0, 0, 0, 0, 0, 0, "R4 land");
    // R5: PC+4 carries into the top nibble
    m_pc = 32'hEFFF_FFFC;
    step(1, 7, 0, 0, 0, 26'h3FF_FFFF, 0, "R5 jump carry");
    step(1, 0, 0, 0, 0, 0, 0, "R5 slot");
    step(1, 0, 0, 0, 0, 0, 0, "R5 land");
    // R6
    step(1, 8, 0, 0, 0, 0, 32'hDEAD_BEEF, "R6 jr");
    step(1, 0, 0, 0, 0, 0, 0, "R6 slot");
    step(1, 0, 0, 0, 0, 0, 0, "R6 land");
    // R7
    m_pc = 32'h0000_2000;
    step(1, 9, 0, 0, 0, 26'h0000_123, 0, "R7 jal");
    step(1, 0, 0, 0, 0, 0, 0, "R7 slot");
    // R9: jal in a delay slot is suppressed
    step(1, 1, 7, 7, 16'h40, 0, 0, "R9 branch");
    step(1, 9, 0, 0, 0, 26'h155, 0, "R9 jal in slot");
    step(1, 8, 0, 0, 0, 0, 32'h400, "R9 after slot");
    step(1, 0, 0, 0, 0, 0, 0, "R9 slot2");
    // R10: stalls between branch and slot
    step(1, 1, 3, 3, 16'h20, 0, 0, "R10 branch");
    for (int i = 0; i < 4; i++) step(0, 9, 0, 0, 0, 26'h7, 0, "R10 stall");
    step(1, 0, 0, 0, 0, 0, 0, "R10 slot");
    step(1, 0, 0, 0, 0, 0, 0, "R10 land");
    // R11: undefined kinds
    for (int k = 10; k < 16; k++) step(1, k, 9, 9, 16'h8, 26'h8, 32'h80, "R11 undefined");
    step(1, 0, 9, 9, 16'h8, 0, 0, "R11 none");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ra, rb;
      int sel;
      ra = $urandom;
      sel = $urandom % 8;
      if (sel == 0) ra = 32'h0;
      else if (sel == 1) ra = 32'hFFFF_FFFF;
      else if (sel == 2) ra = 32'h8000_0000;
      rb = ($urandom % 3 == 0) ? ra : $urandom;
      step(($urandom % 5) != 0, $urandom % 16, ra, rb, 16'($urandom),
           26'($urandom), $urandom & 32'hFFFF_FFFC, "R2 R3 R4 R8 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule